// File: doc/BRIEF.md
# Memory-Mapped Button and LED Target

This block is a target on a single-initiator, four-phase bus. The bus uses an active-low request and an active-low acknowledge. The target owns two bus locations. One is a read-only location that reports the level of a push-button. The other is a write-only location that holds the state of one LED.

The bus has no clock, so the block first passes the request, address, command, write data and button level through a multi-stage synchronizer. It then decodes the address together with the direction of the access. A read of the button location loads the read bus and enables the read data output. One clock later it pulls acknowledge low. A write to the LED location stores bit 0 of the write data and pulls acknowledge low in the same clock.

The target holds acknowledge low until request returns high. It then releases acknowledge and stops driving read data, which ends the transaction. Any access it does not own is left without an answer and has no effect. This covers unmapped addresses, a write to the button location and a read of the LED location.

Top module: `mmio_hs_target`

## Requirements
- R1: After reset, ack_n is 1, rd_oe is 0, rd_data is 0 and led is 0 (off).
- R2: A read (cmd=0) at address 0x04 is acknowledged. While ack_n is low, rd_data carries the button level in bit 0 (1 = pressed) and zeros in bits 7 to 1.
- R3: For an acknowledged read, rd_oe is already 1 at least one clock before ack_n goes low.
- R4: A write (cmd=1) at address 0x05 is acknowledged, and led equals bit 0 of wr_data (1 = on) by the time ack_n is low.
- R5: ack_n stays low while req_n is low. After req_n returns high, ack_n returns to 1 and rd_oe and rd_data return to 0 within a few clocks.
- R6: A write to 0x04 or a read from 0x05 gets no acknowledge, never enables rd_oe and leaves led unchanged.
- R7: An access to any other address gets no acknowledge, never enables rd_oe and leaves led unchanged.
- R8: led changes only on an acknowledged write to 0x05. Button reads leave it unchanged.
- R9: ack_n never goes low unless req_n has been seen low. While the bus is idle, ack_n stays high.
- R10: Bits 7 to 1 of wr_data are ignored by an LED write. A write of 0xFE turns the LED off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Bus request, active low, asynchronous |
| addr | input | 8 | Bus address |
| cmd | input | 1 | Access direction: 0 read, 1 write |
| wr_data | input | 8 | Write data from the initiator |
| button | input | 1 | Push-button level, 1 when pressed |
| rd_data | output | 8 | Read data to the initiator, zero when not enabled |
| rd_oe | output | 1 | Read data output enable |
| ack_n | output | 1 | Bus acknowledge, active low |
| led | output | 1 | LED state, 1 is on |

## Verification
Button reads are tried with the button both pressed and released. This shows that bit 0 follows the live level and is not a constant. LED writes use the values 0x01, 0xFE and 0x03, which shows that only bit 0 is stored. The wrong-direction accesses (a write to 0x04, a read of 0x05) and accesses to unmapped addresses are each followed by a read-back of led and a long wait for an acknowledge that must not come. This separates a decoder that checks the direction from one that checks only the address. Every answered transaction is also watched through its release, to confirm that acknowledge and data are given up in order.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_PRESENT = 2'd1,
        S_DONE    = 2'd2,
        S_SKIP    = 2'd3
    } tgt_state_e;

endpackage

// File: rtl/mmio_sync.sv
module mmio_sync #(
    parameter int unsigned   W       = 1,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mmio_decode.sv
module mmio_decode #(
    parameter int unsigned          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]    BTN_ADDR = 8'h04,
    parameter logic [ADDR_W-1:0]    LED_ADDR = 8'h05
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              cmd,
    output logic              hit_btn_rd,
    output logic              hit_led_wr
);
    always_comb begin
        hit_btn_rd = (addr == BTN_ADDR) && !cmd;
        hit_led_wr = (addr == LED_ADDR) &&  cmd;
    end
endmodule

// File: rtl/mmio_hs_target.sv
module mmio_hs_target
    import mmio_pkg::*;
#(
    parameter int unsigned          ADDR_W      = 8,
    parameter int unsigned          DATA_W      = 8,
    parameter int unsigned          SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0]    BTN_ADDR    = 8'h04,
    parameter logic [ADDR_W-1:0]    LED_ADDR    = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cmd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              button,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe,
    output logic              ack_n,
    output logic              led
);
    localparam int unsigned    SW       = DATA_W + ADDR_W + 3;
    localparam logic [SW-1:0]  SYNC_RST = SW'(1);   // request idles high

    typedef struct packed {
        tgt_state_e        st;
        logic              ack_n;
        logic              oe;
        logic [DATA_W-1:0] rdata;
        logic              led;
    } tgt_regs_t;

    logic [SW-1:0]     sync_in, sync_out;
    logic              req_n_s, cmd_s, btn_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] wdata_s;
    logic              hit_btn_rd, hit_led_wr;
    tgt_regs_t         r_d, r_q;

    assign sync_in = {button, wr_data, addr, cmd, req_n};

    mmio_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_in),
        .q     (sync_out)
    );

    assign {btn_s, wdata_s, addr_s, cmd_s, req_n_s} = sync_out;

    mmio_decode #(.ADDR_W(ADDR_W), .BTN_ADDR(BTN_ADDR), .LED_ADDR(LED_ADDR)) u_dec (
        .addr       (addr_s),
        .cmd        (cmd_s),
        .hit_btn_rd (hit_btn_rd),
        .hit_led_wr (hit_led_wr)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE: begin
                if (!req_n_s) begin
                    if (hit_btn_rd) begin
                        r_d.rdata = {{(DATA_W-1){1'b0}}, btn_s};
                        r_d.oe    = 1'b1;
                        r_d.st    = S_PRESENT;
                    end else if (hit_led_wr) begin
                        r_d.led   = wdata_s[0];
                        r_d.ack_n = 1'b0;
                        r_d.st    = S_DONE;
                    end else begin
                        r_d.st    = S_SKIP;
                    end
                end
            end
            S_PRESENT: begin
                // data has been on the bus for one clock: acknowledge now
                r_d.ack_n = 1'b0;
                r_d.st    = S_DONE;
            end
            S_DONE: begin
                if (req_n_s) begin
                    r_d.ack_n = 1'b1;
                    r_d.oe    = 1'b0;
                    r_d.rdata = '0;
                    r_d.st    = S_IDLE;
                end
            end
            S_SKIP: begin
                if (req_n_s) r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= S_IDLE;
            r_q.ack_n <= 1'b1;
            r_q.oe    <= 1'b0;
            r_q.rdata <= '0;
            r_q.led   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data = r_q.rdata;
    assign rd_oe   = r_q.oe;
    assign ack_n   = r_q.ack_n;
    assign led     = r_q.led;

    // R1: idle means nothing is driven and no acknowledge
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE) |-> (ack_n && !rd_oe));

    // R2: upper read bits never carry anything
    p_rdata_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[DATA_W-1:1] == '0));

    // R3: output enable leads acknowledge on reads
    p_oe_leads_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_n) && rd_oe) |-> $past(rd_oe));

    // R5: acknowledge held while request is low
    p_ack_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !req_n_s) |=> !ack_n);

    // R5: release once request is seen high
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && req_n_s) |=> (ack_n && !rd_oe));

    // R8: LED moves only together with an acknowledge
    p_led_only_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (led != $past(led)) |-> $fell(ack_n));

    // R9: no acknowledge without a request seen low
    p_no_spont_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> !$past(req_n_s));
endmodule

// File: tb/sim_mmio_hs_target.sv
module sim_mmio_hs_target;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_n = 1'b1;
    logic [7:0] addr = '0;
    logic       cmd = 1'b0;
    logic [7:0] wr_data = '0;
    logic       button = 1'b0;
    logic [7:0] rd_data;
    logic       rd_oe, ack_n, led;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mmio_hs_target u0 (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .addr(addr), .cmd(cmd),
        .wr_data(wr_data), .button(button), .rd_data(rd_data),
        .rd_oe(rd_oe), .ack_n(ack_n), .led(led)
    );

    typedef struct {
        string  tag;
        bit     acked;
        bit     is_rd;
        logic [7:0] rdata;
        bit     oe_lead;
        bit     released;
        bit     oe_seen;
        bit     led;
    } item_t;

    item_t exp_q[$];
    item_t obs_q[$];
    bit    led_model = 1'b0;

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_xfer(string tag, logic [7:0] a, logic c, logic [7:0] d);
        item_t e, o;
        bit prev_oe;
        e.tag   = tag;
        e.is_rd = !c;
        e.acked = ((a == 8'h04) && !c) || ((a == 8'h05) && c);
        e.rdata = {7'b0, button};
        e.oe_lead  = 1'b1;
        e.released = 1'b1;
        e.oe_seen  = e.acked && !c;
        if ((a == 8'h05) && c) led_model = d[0];
        e.led = led_model;
        exp_q.push_back(e);

        o = '{tag: tag, acked: 0, is_rd: !c, rdata: 0, oe_lead: 0,
              released: 1, oe_seen: 0, led: 0};
        @(negedge clk);
        addr = a; cmd = c; wr_data = d;
        @(negedge clk);
        req_n = 1'b0;
        prev_oe = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rd_oe) o.oe_seen = 1'b1;
            if (!ack_n) begin
                o.acked   = 1'b1;
                o.rdata   = rd_data;
                o.oe_lead = prev_oe;
                break;
            end
            prev_oe = rd_oe;
        end
        o.led = led;
        req_n = 1'b1;
        o.released = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (rd_oe) o.oe_seen = 1'b1;
            if (ack_n && !rd_oe && rd_data == 8'h00) begin
                o.released = 1'b1;
                break;
            end
        end
        repeat (3) @(negedge clk);
        if (!o.acked) o.led = led;   // state brought out after ignored access
        obs_q.push_back(o);
    endtask

    // monitor: compares observations against expected items
    initial begin
        forever begin
            item_t e, o;
            wait (obs_q.size() > 0);
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            if (e.acked) chk(e.tag, "ack", o.acked, e.acked);
            else         chk(e.tag, "ack (R6/R7 none expected)", o.acked, e.acked);
            chk("R6/R7", {e.tag, " oe enable"}, o.oe_seen, e.oe_seen);
            if (e.acked && e.is_rd) begin
                chk("R2", {e.tag, " rdata"}, o.rdata, e.rdata);
                chk("R3", {e.tag, " oe before ack"}, o.oe_lead, e.oe_lead);
            end
            if (e.acked) chk("R5", {e.tag, " release"}, o.released, e.released);
            chk("R8", {e.tag, " led"}, o.led, e.led);
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                n_vec++;
                $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
                $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ack_n after reset", ack_n, 1);
        chk("R1", "rd_oe after reset", rd_oe, 0);
        chk("R1", "rd_data after reset", rd_data, 0);
        chk("R1", "led after reset", led, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R9", "ack_n idle", ack_n, 1);

        button = 1'b1; repeat (4) @(negedge clk);
        bus_xfer("R2 btn pressed", 8'h04, 1'b0, 8'h00);
        button = 1'b0; repeat (4) @(negedge clk);
        bus_xfer("R2 btn released", 8'h04, 1'b0, 8'h00);
        bus_xfer("R4 led on", 8'h05, 1'b1, 8'h01);
        bus_xfer("R10 led 0xFE", 8'h05, 1'b1, 8'hFE);
        bus_xfer("R4 led 0x03", 8'h05, 1'b1, 8'h03);
        bus_xfer("R6 write btn", 8'h04, 1'b1, 8'h00);
        bus_xfer("R6 read led", 8'h05, 1'b0, 8'h00);
        bus_xfer("R7 write 0x07", 8'h07, 1'b1, 8'h00);
        bus_xfer("R7 read 0x00", 8'h00, 1'b0, 8'h00);
        bus_xfer("R7 write 0x85", 8'h85, 1'b1, 8'h00);
        button = 1'b1; repeat (4) @(negedge clk);
        bus_xfer("R8 read keeps led", 8'h04, 1'b0, 8'h00);
        bus_xfer("R4 led off", 8'h05, 1'b1, 8'h00);
        repeat (8) @(negedge clk);
        chk("R9", "ack_n idle at end", ack_n, 1);

        wait (obs_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule